// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight interrupt request lines, ranks them with a fixed priority in which input 0 is the most urgent, and raises a single interrupt line towards the host processor. Each input can be blocked by its own mask bit. When the processor acknowledges, the controller moves the winning request into an in-service register and hands back an 8-bit vector. The vector is made of a programmable base in the upper five bits and the level number in the lower three. A request that is no more urgent than a level already being serviced stays pending until software retires that level with an end-of-interrupt command.

Several controllers can be joined. One acts as master, and slaves feed their interrupt lines into master inputs. When the master's winner is such an input, it places that input number on a 3-bit cascade bus. The slave with the matching identity then supplies the vector. All behaviour is synchronous to one system clock. The acknowledge is modelled as two single-cycle strobes on `ack_pulse`.

Configuration is a short write sequence, handled by a sequencer with the states CFG_WAIT_W1, CFG_W2, CFG_W3, CFG_W4 and CFG_RUN. Its transitions are:
- A setup word on address 0 leads to CFG_W2 from any state.
- From CFG_W2, a write on address 1 leads to CFG_W3 in cascade mode. Otherwise it leads to CFG_W4 when a fourth word was requested, or else to CFG_RUN.
- From CFG_W3, the next address-1 write leads to CFG_W4 or CFG_RUN.
- From CFG_W4, the next address-1 write leads to CFG_RUN.

The acknowledge machine has two states, ACK_IDLE and ACK_SECOND. The first strobe moves it from ACK_IDLE to ACK_SECOND, and the second strobe moves it back. A setup word forces it to ACK_IDLE.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `int_out`, `vec_valid` and `cas_drive` are 0, and the in-service register (read at `addr`=0) and the mask register (read at `addr`=1) both read 0.
- R2: A write to `addr`=0 with `wdata[4]`=1 is the setup word. In it, bit 3 selects level triggering (0 selects edge), bit 1 selects a lone controller (0 selects cascade), and bit 0 requests a fourth word. The setup word clears the request, in-service and mask registers. The following `addr`=1 writes are then taken in order: first the vector base from `wdata[7:3]`, then the cascade word if cascade mode is set, then the fourth word if it was requested. `int_out` stays 0 until the last of these writes.
- R3: In edge mode a request is recorded on a 0-to-1 change of an input. An input held high after its request was acknowledged raises no new request.
- R4: In level mode the request register follows the inputs one cycle later. An input that drops before acknowledge removes its request. An input still high after its level is retired requests again.
- R5: Once configured, a write to `addr`=1 loads the mask register, and it reads back at `addr`=1. A set mask bit keeps its input from raising `int_out`.
- R6: The vector is `{base, level}`, where level is the lowest-numbered unmasked pending request. It appears on `vec_out` with `vec_valid`=1 for exactly the one cycle after the second strobe.
- R7: The first strobe sets the winner's in-service bit, clears its request bit, and drops `int_out` until the sequence ends.
- R8: `int_out` is raised only for a request whose level is lower-numbered than every set in-service bit.
- R9: A write to `addr`=0 with `wdata[4]`=0 and `wdata[7:5]`=3'b001 clears the lowest-numbered set in-service bit.
- R10: If no request qualifies at the first strobe, the vector carries level 7 and the in-service register is unchanged.
- R11: A master (`is_master`=1, cascade mode) whose winner is marked by a 1 in its cascade word gives no vector itself. It drives `cas_out` with the winner's number and holds `cas_drive`=1 from the first strobe until the second.
- R12: A slave (`is_master`=0, cascade mode) takes its identity from cascade-word bits [2:0]. At the second strobe it commits its own winner and gives the vector only if `cas_in` equals that identity; otherwise its state is unchanged and it gives no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | Strap: 1 for master, 0 for slave in cascade mode |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | In-service register (addr 0) or mask register (addr 1) |
| ir | input | 8 | Interrupt request inputs, bit 0 most urgent |
| int_out | output | 1 | Interrupt request to the processor |
| ack_pulse | input | 1 | Acknowledge strobe, one cycle per pulse |
| vec_out | output | 8 | Interrupt vector |
| vec_valid | output | 1 | Vector valid for one cycle |
| cas_in | input | 3 | Cascade bus seen by a slave |
| cas_out | output | 3 | Cascade identity driven by a master |
| cas_drive | output | 1 | Master is driving the cascade bus |

## Verification
A new request edge can arrive in the very cycle in which the first acknowledge strobe commits another level. That cycle both clears one request bit and sets another. The bench raises input 3 on the same clock on which the first strobe takes input 5. It expects vector level 5 from that sequence. It then expects `int_out` to rise again, because 3 outranks the in-service 5, and the next acknowledge to yield level 3. A slave that sees a strobe while a different identity is on the cascade bus is also provoked, and its in-service register is read back unchanged.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [2:0] {
        CFG_WAIT_W1,
        CFG_W2,
        CFG_W3,
        CFG_W4,
        CFG_RUN
    } cfg_state_t;

    typedef enum logic {
        ACK_IDLE,
        ACK_SECOND
    } ack_state_t;
endpackage

// File: rtl/irq_cfg_seq.sv
module irq_cfg_seq
    import irq_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int LVL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   addr,
    input  logic [7:0]             wdata,
    output logic                   running,
    output logic                   level_mode,
    output logic                   single_mode,
    output logic [VEC_W-LVL_W-1:0] base,
    output logic [7:0]             casc_word,
    output logic                   init_pulse,
    output logic                   mask_we,
    output logic                   eoi_pulse
);
    cfg_state_t state, state_n;
    logic       need_w4;
    logic       wr_w1, wr_ctl, wr_dat;
    logic       unused_bit;

    assign wr_w1      = wr_en && !addr && wdata[4];
    assign wr_ctl     = wr_en && !addr && !wdata[4];
    assign wr_dat     = wr_en && addr;
    assign unused_bit = wdata[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CFG_WAIT_W1;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (wr_w1) begin
            state_n = CFG_W2;
        end else begin
            unique case (state)
                CFG_WAIT_W1: state_n = CFG_WAIT_W1;
                CFG_W2: if (wr_dat) state_n = !single_mode ? CFG_W3 :
                                              (need_w4 ? CFG_W4 : CFG_RUN);
                CFG_W3: if (wr_dat) state_n = need_w4 ? CFG_W4 : CFG_RUN;
                CFG_W4: if (wr_dat) state_n = CFG_RUN;
                CFG_RUN: state_n = CFG_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_mode  <= 1'b0;
            single_mode <= 1'b1;
            need_w4     <= 1'b0;
            base        <= '0;
            casc_word   <= '0;
        end else if (wr_w1) begin
            level_mode  <= wdata[3];
            single_mode <= wdata[1];
            need_w4     <= wdata[0];
        end else if (wr_dat && state == CFG_W2) begin
            base <= wdata[VEC_W-1:LVL_W];
        end else if (wr_dat && state == CFG_W3) begin
            casc_word <= wdata;
        end
    end

    assign running    = (state == CFG_RUN);
    assign init_pulse = wr_w1;
    assign mask_we    = wr_dat && running;
    assign eoi_pulse  = wr_ctl && running && (wdata[7:5] == 3'b001);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_IR = 8,
    parameter int VEC_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     is_master,
    input  logic                     wr_en,
    input  logic                     addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic [NUM_IR-1:0]        ir,
    output logic                     int_out,
    input  logic                     ack_pulse,
    output logic [VEC_W-1:0]         vec_out,
    output logic                     vec_valid,
    input  logic [$clog2(NUM_IR)-1:0] cas_in,
    output logic [$clog2(NUM_IR)-1:0] cas_out,
    output logic                     cas_drive
);
    localparam int LVL_W  = $clog2(NUM_IR);
    localparam int BASE_W = VEC_W - LVL_W;

    logic              running, level_mode, single_mode;
    logic [BASE_W-1:0] base;
    logic [7:0]        casc_word;
    logic              init_pulse, mask_we, eoi_pulse;

    logic [NUM_IR-1:0] ir_q, irr, imr, isr;
    logic [NUM_IR-1:0] cand, set_bit, clr_req, clr_srv;
    logic              req_hit, srv_hit, allow;
    logic [LVL_W-1:0]  req_idx, srv_idx, my_id, lvl_q;
    logic              is_slave_chip, id_match, ack1, ack2, commit, to_slave;
    ack_state_t        ack_st, ack_st_n;

    irq_cfg_seq #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .running(running), .level_mode(level_mode), .single_mode(single_mode),
        .base(base), .casc_word(casc_word), .init_pulse(init_pulse),
        .mask_we(mask_we), .eoi_pulse(eoi_pulse)
    );

    assign cand = irr & ~imr;

    irq_prio_pick #(.N(NUM_IR), .W(LVL_W)) u_req_pick (
        .req(cand), .hit(req_hit), .idx(req_idx)
    );
    irq_prio_pick #(.N(NUM_IR), .W(LVL_W)) u_srv_pick (
        .req(isr), .hit(srv_hit), .idx(srv_idx)
    );

    assign allow         = req_hit && (!srv_hit || (req_idx < srv_idx));
    assign is_slave_chip = !single_mode && !is_master;
    assign my_id         = casc_word[LVL_W-1:0];
    assign id_match      = (cas_in == my_id);
    assign ack1          = running && ack_pulse && (ack_st == ACK_IDLE);
    assign ack2          = running && ack_pulse && (ack_st == ACK_SECOND);
    assign commit        = allow && ((ack1 && !is_slave_chip) ||
                                     (ack2 && is_slave_chip && id_match));
    assign set_bit       = commit ? (NUM_IR'(1) << req_idx) : '0;
    assign clr_req       = set_bit;
    assign clr_srv       = (eoi_pulse && srv_hit) ? (NUM_IR'(1) << srv_idx) : '0;

    // request, in-service and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
            irr  <= '0;
            isr  <= '0;
            imr  <= '0;
        end else begin
            ir_q <= ir;
            if (init_pulse) begin
                irr <= '0;
                isr <= '0;
                imr <= '0;
            end else begin
                irr <= level_mode ? ir : ((irr & ~clr_req) | (ir & ~ir_q));
                isr <= (isr & ~clr_srv) | set_bit;
                if (mask_we) imr <= wdata;
            end
        end
    end

    // acknowledge state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_st <= ACK_IDLE;
        else        ack_st <= ack_st_n;
    end

    always_comb begin
        ack_st_n = ack_st;
        if (init_pulse) begin
            ack_st_n = ACK_IDLE;
        end else begin
            unique case (ack_st)
                ACK_IDLE:   if (ack1) ack_st_n = ACK_SECOND;
                ACK_SECOND: if (ack2) ack_st_n = ACK_IDLE;
            endcase
        end
    end

    // acknowledge outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q     <= '0;
            to_slave  <= 1'b0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= 1'b0;
            if (init_pulse) begin
                to_slave <= 1'b0;
            end else if (ack1) begin
                lvl_q    <= allow ? req_idx : '1;
                to_slave <= !single_mode && is_master && allow && casc_word[req_idx];
            end else if (ack2) begin
                to_slave <= 1'b0;
                if (is_slave_chip) begin
                    if (id_match) begin
                        vec_valid <= 1'b1;
                        vec_out   <= {base, (allow ? req_idx : {LVL_W{1'b1}})};
                    end
                end else if (!to_slave) begin
                    vec_valid <= 1'b1;
                    vec_out   <= {base, lvl_q};
                end
            end
        end
    end

    assign int_out   = running && (ack_st == ACK_IDLE) && allow;
    assign cas_drive = (ack_st == ACK_SECOND) && to_slave;
    assign cas_out   = cas_drive ? lvl_q : '0;
    assign rdata     = addr ? imr : isr;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_IR = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ack_pulse,
    input logic                      running,
    input logic                      is_master,
    input logic                      single_mode,
    input logic                      int_out,
    input logic                      vec_valid,
    input logic                      cas_drive,
    input logic [$clog2(NUM_IR)-1:0] cas_out,
    input logic [$clog2(NUM_IR)-1:0] cas_in,
    input logic [$clog2(NUM_IR)-1:0] my_id,
    input logic [NUM_IR-1:0]         isr,
    input logic                      eoi_pulse,
    input logic                      init_pulse,
    input logic                      ack_second
);
    // R6: vector strobe lasts a single cycle
    a_r6_vec_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R7: first strobe removes the interrupt request line
    a_r7_int_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ack_pulse && !ack_second) |=> !int_out);

    // R9: end-of-interrupt retires exactly one level
    a_r9_eoi_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && (isr != '0) && !ack_pulse) |=>
        ($countones(isr) == $countones($past(isr)) - 1));

    // R11: cascade identity held steady between strobes
    a_r11_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_drive && !ack_pulse && !init_pulse) |=> (cas_drive && $stable(cas_out)));

    // R12: a slave gives a vector only for its own identity
    a_r12_slave_match: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !is_master && !single_mode) |-> ($past(cas_in) == my_id));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_IR(NUM_IR)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_pulse(ack_pulse), .running(running),
    .is_master(is_master), .single_mode(single_mode), .int_out(int_out),
    .vec_valid(vec_valid), .cas_drive(cas_drive), .cas_out(cas_out),
    .cas_in(cas_in), .my_id(my_id), .isr(isr), .eoi_pulse(eoi_pulse),
    .init_pulse(init_pulse), .ack_second(ack_st == irq_pkg::ACK_SECOND)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_m = 1'b0, wr_s = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, ir_m = '0, ir_s = '0, m_ir;
    logic [7:0] m_rdata, s_rdata, m_vec, s_vec;
    logic       m_int, s_int, m_vv, s_vv, m_cd, s_cd;
    logic [2:0] m_cas, s_cas;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign m_ir = ir_m | (s_int ? 8'h04 : 8'h00);

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .wr_en(wr_m), .addr(addr),
        .wdata(wdata), .rdata(m_rdata), .ir(m_ir), .int_out(m_int),
        .ack_pulse(ack), .vec_out(m_vec), .vec_valid(m_vv), .cas_in(3'b000),
        .cas_out(m_cas), .cas_drive(m_cd)
    );

    irq_prio_ctrl uut_slv (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .wr_en(wr_s), .addr(addr),
        .wdata(wdata), .rdata(s_rdata), .ir(ir_s), .int_out(s_int),
        .ack_pulse(ack), .vec_out(s_vec), .vec_valid(s_vv), .cas_in(m_cas),
        .cas_out(s_cas), .cas_drive(s_cd)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic to_slave, input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (to_slave) wr_s = 1'b1; else wr_m = 1'b1;
        @(negedge clk);
        wr_s = 1'b0; wr_m = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic slv, input logic a,
                          input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, slv ? s_rdata : m_rdata, exp);
    endtask

    task automatic pulse();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    // driver: expected vector goes to the scoreboard, then the two strobes
    task automatic do_ack(input logic [7:0] exp);
        exp_q.push_back(exp);
        pulse();
        pulse();
    endtask

    // monitor: compares vectors as they appear
    always @(negedge clk) begin
        if (rst_n && (m_vv || s_vv)) begin
            if (m_vv && s_vv) begin
                check("R11 one vector source", 8'h01, 8'h00);
            end else if (exp_q.size() == 0) begin
                check("R6 unexpected vector", m_vv ? m_vec : s_vec, 8'hxx);
            end else begin
                check("R6 vector", m_vv ? m_vec : s_vec, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(3);
        check("R1 int_out", {7'b0, m_int}, 8'h00);
        check("R1 vec_valid", {7'b0, m_vv}, 8'h00);
        check("R1 cas_drive", {7'b0, m_cd}, 8'h00);
        rd_chk("R1 in-service", 1'b0, 1'b0, 8'h00);
        rd_chk("R1 mask", 1'b0, 1'b1, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        // R2: single, edge, fourth word requested
        wr(1'b0, 1'b0, 8'h13);
        @(negedge clk) ir_m[4] = 1'b1;
        tick(2);
        check("R2 not ready after setup", {7'b0, m_int}, 8'h00);
        wr(1'b0, 1'b1, 8'h20);
        tick(1);
        check("R2 waits for fourth word", {7'b0, m_int}, 8'h00);
        wr(1'b0, 1'b1, 8'h01);
        tick(1);
        check("R2 ready after last word", {7'b0, m_int}, 8'h01);

        // R7: first strobe commits and drops int
        exp_q.push_back(8'h24);
        pulse();
        check("R7 int low between strobes", {7'b0, m_int}, 8'h00);
        rd_chk("R7 in-service set", 1'b0, 1'b0, 8'h10);
        pulse();
        tick(1);
        check("R3 held input no re-request", {7'b0, m_int}, 8'h00);
        wr(1'b0, 1'b0, 8'h20);
        rd_chk("R9 eoi clears", 1'b0, 1'b0, 8'h00);
        check("R3 still quiet after eoi", {7'b0, m_int}, 8'h00);
        @(negedge clk) ir_m[4] = 1'b0;

        // R8 nesting
        @(negedge clk) ir_m[6] = 1'b1;
        tick(1);
        do_ack(8'h26);
        @(negedge clk) ir_m[7] = 1'b1;
        tick(1);
        check("R8 lower level blocked", {7'b0, m_int}, 8'h00);
        @(negedge clk) ir_m[1] = 1'b1;
        tick(1);
        check("R8 higher level allowed", {7'b0, m_int}, 8'h01);
        do_ack(8'h21);
        rd_chk("R8 nested in-service", 1'b0, 1'b0, 8'h42);
        wr(1'b0, 1'b0, 8'h20);
        rd_chk("R9 lowest bit retired", 1'b0, 1'b0, 8'h40);
        check("R8 level 7 still blocked by 6", {7'b0, m_int}, 8'h00);
        wr(1'b0, 1'b0, 8'h20);
        tick(1);
        check("R8 level 7 released", {7'b0, m_int}, 8'h01);
        do_ack(8'h27);
        wr(1'b0, 1'b0, 8'h20);
        @(negedge clk) ir_m = '0;

        // R5 mask
        wr(1'b0, 1'b1, 8'h08);
        rd_chk("R5 mask readback", 1'b0, 1'b1, 8'h08);
        @(negedge clk) ir_m[3] = 1'b1;
        tick(2);
        check("R5 masked input silent", {7'b0, m_int}, 8'h00);
        wr(1'b0, 1'b1, 8'h00);
        tick(1);
        check("R5 unmasked input raises", {7'b0, m_int}, 8'h01);
        do_ack(8'h23);
        wr(1'b0, 1'b0, 8'h20);
        @(negedge clk) ir_m = '0;

        // R10 spurious
        tick(1);
        check("R10 no request", {7'b0, m_int}, 8'h00);
        do_ack(8'h27);
        rd_chk("R10 in-service unchanged", 1'b0, 1'b0, 8'h00);

        // concurrency: new edge in the first-strobe cycle
        @(negedge clk) ir_m[5] = 1'b1;
        tick(1);
        exp_q.push_back(8'h25);
        @(negedge clk) begin ack = 1'b1; ir_m[3] = 1'b1; end
        @(negedge clk) ack = 1'b0;
        pulse();
        tick(1);
        check("R8 edge during strobe stays pending", {7'b0, m_int}, 8'h01);
        do_ack(8'h23);
        rd_chk("R7 both in service", 1'b0, 1'b0, 8'h28);
        wr(1'b0, 1'b0, 8'h20);
        wr(1'b0, 1'b0, 8'h20);
        @(negedge clk) ir_m = '0;

        // R4 level mode
        wr(1'b0, 1'b0, 8'h1A);
        wr(1'b0, 1'b1, 8'h30);
        @(negedge clk) ir_m[2] = 1'b1;
        tick(1);
        check("R4 level request", {7'b0, m_int}, 8'h01);
        @(negedge clk) ir_m[2] = 1'b0;
        tick(1);
        check("R4 dropped input withdraws", {7'b0, m_int}, 8'h00);
        @(negedge clk) ir_m[2] = 1'b1;
        tick(1);
        do_ack(8'h32);
        wr(1'b0, 1'b0, 8'h20);
        tick(1);
        check("R4 still-high input re-requests", {7'b0, m_int}, 8'h01);
        @(negedge clk) ir_m[2] = 1'b0;
        tick(1);
        check("R4 request follows input", {7'b0, m_int}, 8'h00);

        // R11/R12 cascade: master input 2 carries slave id 2
        wr(1'b0, 1'b0, 8'h10);
        wr(1'b0, 1'b1, 8'h40);
        wr(1'b0, 1'b1, 8'h04);
        wr(1'b1, 1'b0, 8'h10);
        wr(1'b1, 1'b1, 8'h80);
        wr(1'b1, 1'b1, 8'h02);
        @(negedge clk) ir_s[6] = 1'b1;
        tick(3);
        check("R11 master sees slave request", {7'b0, m_int}, 8'h01);
        exp_q.push_back(8'h86);
        pulse();
        check("R11 cas_drive", {7'b0, m_cd}, 8'h01);
        check("R11 cas_out", {5'b0, m_cas}, 8'h02);
        pulse();
        tick(1);
        check("R11 cas released", {7'b0, m_cd}, 8'h00);
        rd_chk("R12 slave in-service", 1'b1, 1'b0, 8'h40);
        rd_chk("R11 master in-service", 1'b0, 1'b0, 8'h04);
        wr(1'b0, 1'b0, 8'h20);
        wr(1'b0, 1'b1, 8'h04);
        @(negedge clk) begin ir_s = 8'h02; ir_m[5] = 1'b1; end
        tick(3);
        exp_q.push_back(8'h45);
        pulse();
        check("R11 direct input no cascade", {7'b0, m_cd}, 8'h00);
        pulse();
        tick(1);
        rd_chk("R12 mismatched slave unchanged", 1'b1, 1'b0, 8'h40);

        tick(3);
        check("R6 all vectors seen", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule